// File: doc/BRIEF.md
# Ready/Busy Status Pin Controller

This block drives the single open-drain status line of a flash-style memory controller. A 2-bit mode register decides what the line reports. In level mode it shows whether the internal operation engine is busy. In each of three pulse modes it gives a short low-going pulse when an operation of a selected kind finishes, so the line can serve as a system interrupt. The output `pin_pull_o` is a pull-down enable. A value of 1 means the pad drives low. A value of 0 means the pad is released to high impedance, and an external pull-up then holds the line high.

The mode register is written through a strobe and a code. It falls back to level mode at power-up, when the device reset request is raised, and when the device leaves deep power-down. Writes are ignored while the reset request or power-down is active. A code above 3 leaves the mode unchanged and raises a one-cycle sequence-error flag for the status logic.

The completion event arrives as a one-cycle strobe tagged with a 3-bit operation class. In level mode the line is released during erase suspend, write suspend and power-down. The exception is a reset request that arrives while the engine is busy: the line then stays low until the engine reports that it is idle.

Top module: `rdy_status_pin`

## Requirements
- R1: After the asynchronous reset is released, the mode is level (code 0), `pin_pull_o` is 0 and `cfg_err_o` is 0.
- R2: In level mode, with no suspend, power-down or reset hold active, `pin_pull_o` in a cycle equals `engine_busy_i` of the previous cycle.
- R3: In level mode, `pin_pull_o` is 0 one cycle after any of `erase_susp_i`, `write_susp_i` or `pwrdn_i` is high, even while `engine_busy_i` is high (unless the R11 hold is active).
- R4: Mode code 1 gives a low pulse (`pin_pull_o` = 1) for exactly PULSE_LEN cycles, starting the cycle after `done_i`, only for classes 0 (block erase), 1 (chip erase) and 2 (clear all lock bits).
- R5: Mode code 2 pulses the same way only for classes 3 (single write), 4 (multi write) and 5 (set block lock bit).
- R6: Mode code 3 pulses for classes 0 to 5. Classes 6 and 7 never cause a pulse in any mode.
- R7: In pulse modes `pin_pull_o` is 0 whenever no pulse is running, whatever the value of `engine_busy_i`.
- R8: A write with a code above 3 leaves the mode unchanged and sets `cfg_err_o` to 1 for exactly the next cycle. `cfg_err_o` is 1 at no other time.
- R9: A high `devrst_i` forces level mode. Configuration writes made while `devrst_i` or `pwrdn_i` is high are ignored and raise no error.
- R10: A falling `pwrdn_i` returns the mode to level.
- R11: If `devrst_i` is seen while `engine_busy_i` is high, `pin_pull_o` is held at 1 from the second cycle after that onward, including through power-down, until the cycle after `engine_busy_i` falls.
- R12: A qualifying completion that arrives during a running pulse restarts it, so the line stays low for PULSE_LEN cycles after the later event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_code_i | input | CODE_W | Configuration code (0..3 valid) |
| engine_busy_i | input | 1 | Operation engine busy flag |
| done_i | input | 1 | One-cycle operation completion strobe |
| done_class_i | input | 3 | Class of the completed operation |
| erase_susp_i | input | 1 | Erase suspended |
| write_susp_i | input | 1 | Write suspended |
| pwrdn_i | input | 1 | Deep power-down active |
| devrst_i | input | 1 | Device reset request |
| pin_pull_o | output | 1 | Pull-down enable; 1 drives the line low, 0 releases it |
| cfg_err_o | output | 1 | One-cycle sequence-error flag for a bad code |

## Verification
The hardest case to reach from the ports is a reset request that lands while the engine is busy and the block is in a pulse mode, followed by power-down. The line must switch from pulse behaviour to the level-mode hold and keep driving low through power-down until the engine goes idle. The stimulus first selects mode 3 and holds `engine_busy_i` high, which in that mode leaves the line released. It then raises `devrst_i`, then `pwrdn_i`, drops `devrst_i`, and only later drops busy, with the line's value expected in each of those cycles. Each pulse mode is also swept over all eight operation classes, and writes made during reset and power-down are checked to show they leave the mode unchanged.

// File: rtl/rdy_pin_pkg.sv
package rdy_pin_pkg;

  typedef enum logic [1:0] {
    MODE_LEVEL       = 2'd0,
    MODE_ERASE_PULSE = 2'd1,
    MODE_WRITE_PULSE = 2'd2,
    MODE_ANY_PULSE   = 2'd3
  } pin_mode_e;

  localparam int unsigned CLASS_W = 3;

  typedef enum logic [CLASS_W-1:0] {
    OP_BLOCK_ERASE = 3'd0,
    OP_CHIP_ERASE  = 3'd1,
    OP_UNLOCK_ALL  = 3'd2,
    OP_WORD_WRITE  = 3'd3,
    OP_MULTI_WRITE = 3'd4,
    OP_LOCK_BLOCK  = 3'd5,
    OP_OTHER_A     = 3'd6,
    OP_OTHER_B     = 3'd7
  } op_class_e;

  // Decide whether a completed operation class qualifies for a pulse in a mode.
  function automatic logic class_selected(pin_mode_e mode, op_class_e cls);
    logic erase_set;
    logic write_set;
    erase_set = (cls == OP_BLOCK_ERASE) || (cls == OP_CHIP_ERASE) || (cls == OP_UNLOCK_ALL);
    write_set = (cls == OP_WORD_WRITE) || (cls == OP_MULTI_WRITE) || (cls == OP_LOCK_BLOCK);
    case (mode)
      MODE_ERASE_PULSE: class_selected = erase_set;
      MODE_WRITE_PULSE: class_selected = write_set;
      MODE_ANY_PULSE:   class_selected = erase_set | write_set;
      default:          class_selected = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rdy_rst_sync.sv
module rdy_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;

  // Assert asynchronously, release after STAGES clock edges.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/rdy_cfg_reg.sv
module rdy_cfg_reg
  import rdy_pin_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              devrst_i,
  input  logic              pwrdn_i,
  output pin_mode_e         mode_o,
  output logic              load_o,
  output logic              err_o
);

  pin_mode_e mode_q, mode_d;
  logic      pwrdn_q;
  logic      err_q, err_d;
  logic      code_ok;
  logic      wr_open;
  logic      force_level;
  logic      mode_en;

  assign code_ok     = (code_i[CODE_W-1:2] == '0);
  assign wr_open     = wr_i & ~devrst_i & ~pwrdn_i;
  assign force_level = devrst_i | (pwrdn_q & ~pwrdn_i);

  always_comb begin
    mode_d  = mode_q;
    mode_en = 1'b0;
    if (force_level) begin
      mode_d  = MODE_LEVEL;
      mode_en = 1'b1;
    end else if (wr_open && code_ok) begin
      mode_d  = pin_mode_e'(code_i[1:0]);
      mode_en = 1'b1;
    end
    err_d = wr_open & ~code_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_LEVEL;
      pwrdn_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (mode_en) begin
        mode_q <= mode_d;
      end
      pwrdn_q <= pwrdn_i;
      err_q   <= err_d;
    end
  end

  assign mode_o = mode_q;
  assign load_o = mode_en;
  assign err_o  = err_q;

endmodule

// File: rtl/rdy_pulse_gen.sv
module rdy_pulse_gen #(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic clear_i,
  output logic pulse_nxt_o
);

  localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clear_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (fire_i) begin
      cnt_d  = CNT_W'(PULSE_LEN);
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - CNT_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign pulse_nxt_o = (cnt_d != '0);

endmodule

// File: rtl/rdy_status_pin.sv
module rdy_status_pin
  import rdy_pin_pkg::*;
#(
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned PULSE_LEN   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [CODE_W-1:0] cfg_code_i,
  input  logic              engine_busy_i,
  input  logic              done_i,
  input  logic [2:0]        done_class_i,
  input  logic              erase_susp_i,
  input  logic              write_susp_i,
  input  logic              pwrdn_i,
  input  logic              devrst_i,
  output logic              pin_pull_o,
  output logic              cfg_err_o
);

  logic      rst_n_sync;
  pin_mode_e mode_q;
  logic      mode_load;
  logic      pulse_fire;
  logic      pulse_clear;
  logic      pulse_nxt;
  logic      hold_q, hold_d;
  logic      level_pull;
  logic      pull_q, pull_d;

  rdy_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  rdy_cfg_reg #(
    .CODE_W (CODE_W)
  ) u_cfg_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_sync),
    .wr_i     (cfg_wr_i),
    .code_i   (cfg_code_i),
    .devrst_i (devrst_i),
    .pwrdn_i  (pwrdn_i),
    .mode_o   (mode_q),
    .load_o   (mode_load),
    .err_o    (cfg_err_o)
  );

  assign pulse_fire  = done_i & (mode_q != MODE_LEVEL)
                     & class_selected(mode_q, op_class_e'(done_class_i));
  assign pulse_clear = mode_load | (mode_q == MODE_LEVEL);

  rdy_pulse_gen #(
    .PULSE_LEN (PULSE_LEN)
  ) u_pulse_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_sync),
    .fire_i      (pulse_fire),
    .clear_i     (pulse_clear),
    .pulse_nxt_o (pulse_nxt)
  );

  // Next-state: a reset request while busy holds the line low until idle.
  always_comb begin
    hold_d     = engine_busy_i & (hold_q | devrst_i);
    level_pull = hold_d
               | (engine_busy_i & ~(erase_susp_i | write_susp_i | pwrdn_i));
    pull_d     = (mode_q == MODE_LEVEL) ? level_pull : pulse_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      hold_q <= 1'b0;
      pull_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      pull_q <= pull_d;
    end
  end

  assign pin_pull_o = pull_q;

endmodule

// File: rtl/rdy_status_pin_chk.sv
module rdy_status_pin_chk #(
  parameter int unsigned CODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              cfg_wr_i,
  input logic [CODE_W-1:0] cfg_code_i,
  input logic              engine_busy_i,
  input logic              done_i,
  input logic              erase_susp_i,
  input logic              write_susp_i,
  input logic              pwrdn_i,
  input logic              devrst_i,
  input logic              pin_pull_o,
  input logic              cfg_err_o,
  input logic [1:0]        mode,
  input logic              hold
);

  logic any_quiet;
  assign any_quiet = erase_susp_i | write_susp_i | pwrdn_i;

  // R2: level mode tracks busy with one cycle of latency
  assert_level_tracks_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(mode) == 2'd0 && !$past(hold) && !$past(devrst_i) && !$past(any_quiet))
      |-> (pin_pull_o == $past(engine_busy_i)));

  // R3: suspend or power-down releases the line in level mode
  assert_quiet_release_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(mode) == 2'd0 && !$past(hold) && !$past(devrst_i) && $past(any_quiet))
      |-> !pin_pull_o);

  // R7: in pulse modes the line only starts a pulse after a completion
  assert_pulse_needs_done_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(mode) != 2'd0 && $rose(pin_pull_o)) |-> $past(done_i));

  // R8: the error flag only follows a write with a bad code
  assert_err_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    cfg_err_o |-> ($past(cfg_wr_i) && ($past(cfg_code_i) > 3)));

  // R9: reset request forces level mode
  assert_devrst_level_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    $past(devrst_i) |-> (mode == 2'd0));

  // R10: leaving power-down forces level mode
  assert_pwrdn_exit_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(pwrdn_i, 2) && !$past(pwrdn_i)) |-> (mode == 2'd0));

  // R11: held reset while busy keeps the line low
  assert_reset_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(mode) == 2'd0 && $past(hold) && $past(engine_busy_i)) |-> pin_pull_o);

endmodule

bind rdy_status_pin rdy_status_pin_chk #(
  .CODE_W (CODE_W)
) chk_i (
  .clk_i         (clk_i),
  .rst_n         (rst_n_sync),
  .cfg_wr_i      (cfg_wr_i),
  .cfg_code_i    (cfg_code_i),
  .engine_busy_i (engine_busy_i),
  .done_i        (done_i),
  .erase_susp_i  (erase_susp_i),
  .write_susp_i  (write_susp_i),
  .pwrdn_i       (pwrdn_i),
  .devrst_i      (devrst_i),
  .pin_pull_o    (pin_pull_o),
  .cfg_err_o     (cfg_err_o),
  .mode          (mode_q),
  .hold          (hold_q)
);

// File: tb/rdy_status_pin_tb_top.sv
module rdy_status_pin_tb_top;

  localparam int unsigned CODE_W    = 8;
  localparam int unsigned PULSE_LEN = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_wr = 1'b0;
  logic [CODE_W-1:0] cfg_code = '0;
  logic              busy = 1'b0;
  logic              done = 1'b0;
  logic [2:0]        cls = '0;
  logic              esusp = 1'b0;
  logic              wsusp = 1'b0;
  logic              pwrdn = 1'b0;
  logic              devrst = 1'b0;
  logic              pull;
  logic              err;

  always #2.5 clk = ~clk;

  rdy_status_pin #(
    .CODE_W    (CODE_W),
    .PULSE_LEN (PULSE_LEN)
  ) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .cfg_wr_i      (cfg_wr),
    .cfg_code_i    (cfg_code),
    .engine_busy_i (busy),
    .done_i        (done),
    .done_class_i  (cls),
    .erase_susp_i  (esusp),
    .write_susp_i  (wsusp),
    .pwrdn_i       (pwrdn),
    .devrst_i      (devrst),
    .pin_pull_o    (pull),
    .cfg_err_o     (err)
  );

  typedef struct {
    int    cyc;
    bit    pull;
    bit    err;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int   cyc = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  // Monitor: compare scoreboard items due in this cycle, away from the edge.
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #2;
      for (int i = sb_q.size() - 1; i >= 0; i--) begin
        if (sb_q[i].cyc == cyc) begin
          n_checks++;
          if (pull !== sb_q[i].pull || err !== sb_q[i].err) begin
            n_fail++;
            $display("FAIL %s cycle %0d: pull=%b err=%b expected pull=%b err=%b",
                     sb_q[i].tag, cyc, pull, err, sb_q[i].pull, sb_q[i].err);
          end
          sb_q.delete(i);
        end else if (sb_q[i].cyc < cyc) begin
          n_checks++;
          n_fail++;
          $display("FAIL %s missed cycle %0d: actual none expected sample", sb_q[i].tag, sb_q[i].cyc);
          sb_q.delete(i);
        end
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_at(int d, bit p, bit e, string tag);
    exp_t it;
    it.cyc  = cyc + d;
    it.pull = p;
    it.err  = e;
    it.tag  = tag;
    sb_q.push_back(it);
  endtask

  task automatic set_mode(int code);
    cfg_wr   = 1'b1;
    cfg_code = CODE_W'(code);
    tick();
    cfg_wr = 1'b0;
    tick(2);
  endtask

  task automatic fire(int c, bit hit, string tag);
    done = 1'b1;
    cls  = 3'(c);
    for (int k = 1; k <= PULSE_LEN; k++) expect_at(k, hit, 1'b0, tag);
    expect_at(PULSE_LEN + 1, 1'b0, 1'b0, tag);
    tick();
    done = 1'b0;
    tick(PULSE_LEN + 2);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // Driver
  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(4);

    // R1: reset state
    expect_at(1, 1'b0, 1'b0, "R1");
    tick(2);

    // R2: level mode follows busy
    busy = 1'b1;
    expect_at(1, 1'b1, 1'b0, "R2");
    tick();
    expect_at(1, 1'b1, 1'b0, "R2");
    tick();
    busy = 1'b0;
    expect_at(1, 1'b0, 1'b0, "R2");
    tick(3);

    // R3: suspend and power-down release the line
    busy  = 1'b1;
    esusp = 1'b1;
    expect_at(1, 1'b0, 1'b0, "R3");
    tick();
    esusp = 1'b0;
    wsusp = 1'b1;
    expect_at(1, 1'b0, 1'b0, "R3");
    tick();
    wsusp = 1'b0;
    expect_at(1, 1'b1, 1'b0, "R3");
    tick();
    pwrdn = 1'b1;
    expect_at(1, 1'b0, 1'b0, "R3");
    tick();
    pwrdn = 1'b0;
    busy  = 1'b0;
    tick(3);

    // R8: bad code flagged, mode kept at level
    cfg_wr   = 1'b1;
    cfg_code = 8'h07;
    expect_at(1, 1'b0, 1'b1, "R8");
    tick();
    cfg_wr = 1'b0;
    expect_at(1, 1'b0, 1'b0, "R8");
    tick();
    busy = 1'b1;
    expect_at(1, 1'b1, 1'b0, "R8");
    tick();
    busy = 1'b0;
    tick(2);

    // R4 / R5 / R6 / R7: each pulse mode swept over all classes with busy high
    for (int m = 1; m <= 3; m++) begin
      set_mode(m);
      busy = 1'b1;
      expect_at(1, 1'b0, 1'b0, "R7");
      expect_at(2, 1'b0, 1'b0, "R7");
      tick(2);
      for (int c = 0; c < 8; c++) begin
        bit hit;
        hit = (m == 1) ? (c <= 2) : (m == 2) ? (c >= 3 && c <= 5) : (c <= 5);
        if (m == 1)      fire(c, hit, "R4");
        else if (m == 2) fire(c, hit, "R5");
        else             fire(c, hit, "R6");
      end
    end

    // R12: retrigger in mode 3 restarts the pulse
    done = 1'b1;
    cls  = 3'd4;
    expect_at(1, 1'b1, 1'b0, "R12");
    expect_at(2, 1'b1, 1'b0, "R12");
    tick();
    done = 1'b0;
    tick();
    done = 1'b1;
    cls  = 3'd0;
    for (int k = 1; k <= PULSE_LEN; k++) expect_at(k, 1'b1, 1'b0, "R12");
    expect_at(PULSE_LEN + 1, 1'b0, 1'b0, "R12");
    tick();
    done = 1'b0;
    tick(PULSE_LEN + 2);

    // R11: reset request while busy in a pulse mode, then power-down
    devrst = 1'b1;
    expect_at(2, 1'b1, 1'b0, "R11");
    tick();
    pwrdn = 1'b1;
    expect_at(2, 1'b1, 1'b0, "R11");
    tick();
    devrst = 1'b0;
    expect_at(1, 1'b1, 1'b0, "R11");
    expect_at(2, 1'b1, 1'b0, "R11");
    tick(2);
    busy = 1'b0;
    expect_at(1, 1'b0, 1'b0, "R11");
    tick();
    pwrdn = 1'b0;
    tick(3);

    // R9: reset request forces level; writes during it are ignored
    set_mode(2);
    devrst = 1'b1;
    tick();
    cfg_wr   = 1'b1;
    cfg_code = 8'h02;
    expect_at(1, 1'b0, 1'b0, "R9");
    tick();
    cfg_wr = 1'b0;
    devrst = 1'b0;
    tick();
    busy = 1'b1;
    expect_at(1, 1'b1, 1'b0, "R9");
    tick();
    busy = 1'b0;
    expect_at(1, 1'b0, 1'b0, "R9");
    tick(2);

    // R10: power-down exit returns to level; bad write during power-down is silent
    set_mode(3);
    pwrdn = 1'b1;
    tick(2);
    cfg_wr   = 1'b1;
    cfg_code = 8'h05;
    expect_at(1, 1'b0, 1'b0, "R10");
    tick();
    cfg_wr = 1'b0;
    tick();
    pwrdn = 1'b0;
    tick();
    busy = 1'b1;
    expect_at(1, 1'b1, 1'b0, "R10");
    tick();
    busy = 1'b0;
    expect_at(1, 1'b0, 1'b0, "R10");
    tick(4);

    if (sb_q.size() != 0) begin
      n_checks++;
      n_fail++;
      $display("FAIL scoreboard: actual %0d items left expected 0", sb_q.size());
    end
    finish_run();
  end

endmodule